// File: doc/BRIEF.md
# Processor Clock-Stop Power-State Controller

This controller sequences a processor core through four power states: running (Normal), halted with the bus clock still live (AutoHALT), clock-stopped with snooping still possible (Stop-Grant), and a deep sleep in which every internal clock is gated. The state changes are driven by requests from the chipset side: a halt request, a level stop-clock request, a level sleep request, and a break event such as an interrupt.

Stop-Grant is not entered as soon as the stop-clock request arrives. The controller first asks the bus unit to run an acknowledge cycle and holds that request until the bus unit reports the response phase. It then counts a fixed number of bus-clock ticks before it switches state. The controller remembers whether it left from Normal or AutoHALT, so that it returns to that state when stop-clock is released. Two one-cycle flags report protocol misuse. One is for stop-clock released before Stop-Grant is reached. The other is for a sleep request made outside the stop-clock states.

Top module: `pwr_clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low the state is Normal (`state_o` = 0), `ack_req`, `proto_err` and `sleep_err` are 0, and `core_clk_en` and `snoop_ok` are 1. The state codes are Normal=0, AutoHALT=1, Stop-Grant=2, Sleep=3.
- R2: With no stop sequence in progress and `stpclk_req` low, `halt_req` in Normal gives AutoHALT at the next edge. `wake_evt` in AutoHALT gives Normal at the next edge.
- R3: `stpclk_req` high in Normal or AutoHALT, with no sequence in progress, raises `ack_req` at the next edge. `ack_req` stays high until an edge where `ack_rsp` is sampled high, and then drops.
- R4: After the response edge, the state becomes Stop-Grant at the edge of the GRANT_DLY-th (default 20) edge with `bus_tick` high. Until then it stays Normal or AutoHALT. Edges with `bus_tick` low do not count.
- R5: If `stpclk_req` falls while `ack_req` is high or ticks are being counted, then at the next edge the sequence is dropped, `ack_req` is 0, the state is unchanged, and `proto_err` is high for exactly one cycle.
- R6: In Stop-Grant with `stpclk_req` high, `sleep_req` gives Sleep at the next edge. In Sleep, `sleep_req` low gives Stop-Grant at the next edge. Sleep is entered from no other state.
- R7: `sleep_req` sampled high in Normal or AutoHALT sets `sleep_err` for the following cycle and does not change the state.
- R8: In Stop-Grant, `stpclk_req` low returns the state at the next edge to the state (Normal or AutoHALT) from which the stop sequence began.
- R9: `core_clk_en` is 1 exactly in Normal and AutoHALT. `snoop_ok` is 0 exactly in Sleep.
- R10: `halt_req` has no effect outside Normal. `wake_evt` has no effect outside AutoHALT, and also has none while a stop sequence is pending.
- R11: Asserting `rst_n` low forces Normal immediately from any state, including Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the core |
| stpclk_req | input | 1 | Stop-clock request level |
| sleep_req | input | 1 | Sleep request level |
| wake_evt | input | 1 | Break event (interrupt) |
| bus_tick | input | 1 | One-cycle pulse per bus clock |
| ack_rsp | input | 1 | Response phase of the acknowledge cycle seen |
| state_o | output | 2 | Current power state code |
| core_clk_en | output | 1 | Internal core clock enable |
| snoop_ok | output | 1 | Snoops may be serviced |
| ack_req | output | 1 | Request to run the stop-grant acknowledge cycle |
| proto_err | output | 1 | Stop-clock released too early (one-cycle pulse) |
| sleep_err | output | 1 | Sleep requested outside stop-clock states (pulse) |

## Verification
The bench places the bus tick right around the boundary of the grant delay. A controller that counts the response edge, or counts edges with no tick, enters Stop-Grant one tick early. One that compares against the wrong limit enters it late. The bench releases stop-clock in the middle of the count and while the acknowledge is still outstanding. A design that neither drops the sequence nor flags it would go on into Stop-Grant or leave `ack_req` stuck high. It also leaves Stop-Grant after entry from both Normal and AutoHALT, which catches a controller that always returns to Normal. It also asserts reset from Sleep. Long randomized runs, checked against an expected-state function, cover sleep and halt requests in wrong states and a wake event during a pending sequence.

// File: rtl/pwr_clkstop_ctrl.sv
module pwr_clkstop_ctrl #(
  parameter int GRANT_DLY = 20,
  localparam int CNT_W = (GRANT_DLY > 2) ? $clog2(GRANT_DLY) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       stpclk_req,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       bus_tick,
  input  logic       ack_rsp,
  output logic [1:0] state_o,
  output logic       core_clk_en,
  output logic       snoop_ok,
  output logic       ack_req,
  output logic       proto_err,
  output logic       sleep_err
);
  localparam logic [1:0] ST_RUN = 2'd0, ST_HLT = 2'd1, ST_SG = 2'd2, ST_SLP = 2'd3;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRANT_DLY - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ACK, PH_CNT} phase_t;

  logic [1:0]       state, home;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  assign state_o     = state;
  assign ack_req     = (phase == PH_ACK);
  assign core_clk_en = (state == ST_RUN) || (state == ST_HLT);
  assign snoop_ok    = (state != ST_SLP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      home      <= ST_RUN;
      phase     <= PH_IDLE;
      cnt       <= '0;
      proto_err <= 1'b0;
      sleep_err <= 1'b0;
    end else begin
      proto_err <= 1'b0;
      sleep_err <= sleep_req && ((state == ST_RUN) || (state == ST_HLT));
      case (phase)
        PH_IDLE:
          case (state)
            ST_RUN, ST_HLT:
              if (stpclk_req) begin
                phase <= PH_ACK;
                home  <= state;
              end else if (state == ST_RUN && halt_req) state <= ST_HLT;
              else if (state == ST_HLT && wake_evt)  state <= ST_RUN;
            ST_SG:
              if (!stpclk_req)    state <= home;
              else if (sleep_req) state <= ST_SLP;
            default:
              if (!sleep_req) state <= ST_SG;
          endcase
        PH_ACK:
          if (!stpclk_req) begin
            phase     <= PH_IDLE;
            proto_err <= 1'b1;
          end else if (ack_rsp) begin
            phase <= PH_CNT;
            cnt   <= '0;
          end
        default:
          if (!stpclk_req) begin
            phase     <= PH_IDLE;
            proto_err <= 1'b1;
          end else if (bus_tick) begin
            if (cnt == CNT_LAST) begin
              phase <= PH_IDLE;
              state <= ST_SG;
            end else cnt <= cnt + 1'b1;
          end
      endcase
    end
  end

  p_sleep_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && $past(state) != ST_SLP) |-> $past(state) == ST_SG);

  p_grant_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SG && $past(state) != ST_SG && $past(state) != ST_SLP) |->
      ($past(phase) == PH_CNT && $past(bus_tick) && $past(cnt) == CNT_LAST));

  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && stpclk_req && !ack_rsp) |=> ack_req);

  p_early_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !stpclk_req) |=> (proto_err && !ack_req && $stable(state)));

  p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HLT && phase == PH_IDLE && !stpclk_req && wake_evt) |=> state == ST_RUN);

  p_sleep_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && state == ST_RUN) |=> (sleep_err && state != ST_SLP));
endmodule

// File: tb/test_pwr_clkstop_ctrl.sv
module test_pwr_clkstop_ctrl;
  localparam int DLY = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req = 0, stpclk_req = 0, sleep_req = 0, wake_evt = 0, bus_tick = 0, ack_rsp = 0;
  logic [1:0] state_o;
  logic core_clk_en, snoop_ok, ack_req, proto_err, sleep_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;

  always #5 clk = ~clk;

  pwr_clkstop_ctrl #(.GRANT_DLY(DLY)) i_pwr_clkstop_ctrl (
    .clk, .rst_n, .halt_req, .stpclk_req, .sleep_req, .wake_evt, .bus_tick, .ack_rsp,
    .state_o, .core_clk_en, .snoop_ok, .ack_req, .proto_err, .sleep_err);

  // expected behaviour, written from the requirements
  int m_st, m_home, m_ph, m_cnt;
  bit m_perr, m_serr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_home = 0; m_ph = 0; m_cnt = 0; m_perr = 0; m_serr = 0;
    end else begin
      m_serr = sleep_req && m_st < 2;
      m_perr = 0;
      if (m_ph != 0 && !stpclk_req) begin m_ph = 0; m_perr = 1; end
      else if (m_ph == 1) begin if (ack_rsp) begin m_ph = 2; m_cnt = 0; end end
      else if (m_ph == 2) begin
        if (bus_tick) begin m_cnt++; if (m_cnt == DLY) begin m_ph = 0; m_st = 2; end end
      end else if (m_st < 2 && stpclk_req) begin m_ph = 1; m_home = m_st; end
      else if (m_st == 0 && halt_req) m_st = 1;
      else if (m_st == 1 && wake_evt) m_st = 0;
      else if (m_st == 2) begin if (!stpclk_req) m_st = m_home; else if (sleep_req) m_st = 3; end
      else if (m_st == 3 && !sleep_req) m_st = 2;
    end
  end

  function automatic bit exp_clk(int s); return s < 2; endfunction
  function automatic bit exp_snp(int s); return s != 3; endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk("R4 state vs model", state_o, m_st);
    chk("R3 ack_req vs model", ack_req, m_ph == 1);
    chk("R5 proto_err vs model", proto_err, m_perr);
    chk("R7 sleep_err vs model", sleep_err, m_serr);
    chk("R9 core_clk_en", core_clk_en, exp_clk(m_st));
    chk("R9 snoop_ok", snoop_ok, exp_snp(m_st));
  end

  // set inputs at a falling edge, then wait one full cycle
  task automatic apply(bit h, bit s, bit sl, bit w, bit t, bit r);
    halt_req = h; stpclk_req = s; sleep_req = sl; wake_evt = w; bus_tick = t; ack_rsp = r;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset ack", ack_req, 0);
    chk("R1 reset clk_en", core_clk_en, 1);
    chk("R1 reset snoop", snoop_ok, 1);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    // halt, stop sequence from AutoHALT
    apply(1,0,0,0,0,0); chk("R2 halt to AutoHALT", state_o, 1);
    apply(0,1,0,0,0,0); chk("R3 ack raised", ack_req, 1);
    apply(0,1,0,1,1,0); chk("R3 ack held", ack_req, 1); chk("R10 wake ignored pending", state_o, 1);
    apply(0,1,0,0,0,1); chk("R3 ack drops on response", ack_req, 0);
    for (int i = 0; i < DLY - 1; i++) begin
      apply(0,1,0,0,1,0); chk("R4 still AutoHALT", state_o, 1);
    end
    apply(0,1,0,0,0,0); chk("R4 no tick no count", state_o, 1);
    apply(0,1,0,0,1,0); chk("R4 Stop-Grant on last tick", state_o, 2);
    chk("R9 clk gated in Stop-Grant", core_clk_en, 0);
    chk("R9 snoop in Stop-Grant", snoop_ok, 1);
    apply(1,1,0,0,0,0); chk("R10 halt ignored", state_o, 2);
    apply(0,1,1,0,0,0); chk("R6 Sleep", state_o, 3); chk("R9 snoop off", snoop_ok, 0);
    apply(0,1,1,0,0,0); chk("R6 stays Sleep", state_o, 3); chk("R7 no error in Sleep", sleep_err, 0);
    apply(0,1,0,0,0,0); chk("R6 back to Stop-Grant", state_o, 2);
    apply(0,0,0,0,0,0); chk("R8 return to AutoHALT", state_o, 1);
    apply(0,0,0,1,0,0); chk("R2 wake to Normal", state_o, 0);
    apply(0,0,0,1,0,0); chk("R10 wake ignored in Normal", state_o, 0);
    apply(0,0,1,0,0,0); chk("R7 sleep_err", sleep_err, 1); chk("R7 state kept", state_o, 0);
    apply(0,0,0,0,0,0); chk("R7 pulse ends", sleep_err, 0);
    // early release while counting, then while awaiting response
    apply(0,1,0,0,0,0); apply(0,1,0,0,0,1);
    repeat (5) apply(0,1,0,0,1,0);
    apply(0,0,0,0,1,0); chk("R5 proto_err", proto_err, 1); chk("R5 state kept", state_o, 0);
    apply(0,0,0,0,0,0); chk("R5 pulse ends", proto_err, 0);
    apply(0,1,0,0,0,0); apply(0,0,0,0,0,0);
    chk("R5 drop during ack", proto_err, 1); chk("R5 ack cleared", ack_req, 0);
    // full sequence from Normal, sleep, then reset
    apply(0,1,0,0,0,0); apply(0,1,0,0,0,1);
    repeat (DLY) apply(0,1,0,0,1,0);
    chk("R4 Stop-Grant from Normal", state_o, 2);
    apply(0,1,1,0,0,0); chk("R6 Sleep again", state_o, 3);
    rst_n = 0; #1; chk("R11 reset from Sleep", state_o, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    // from Normal: release returns to Normal
    apply(0,1,0,0,0,0); apply(0,1,0,0,0,1);
    repeat (DLY) apply(0,1,0,0,1,0);
    apply(0,0,0,0,0,0); chk("R8 return to Normal", state_o, 0);
    // constrained random
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      bit s;
      s = stpclk_req;
      if ($urandom_range(0, 99) < 4) s = !s;
      apply($urandom_range(0,9) == 0, s,
            ($urandom_range(0,99) < 6) ? !sleep_req : sleep_req,
            $urandom_range(0,19) == 0, $urandom_range(0,1) == 1, $urandom_range(0,3) == 0);
    end
    finish_run();
  end
endmodule